// File: doc/BRIEF.md
# Nibble Pixel Scan-Out Expander

This block turns a packed 4-bit grey-level framebuffer into a raster pixel stream for a display pipeline. Each stored byte holds two horizontally adjacent pixels. The block reads the visible rows through a synchronous read port with one cycle of latency. It unpacks both nibbles and widens each grey level to the selected output colour format. Each pixel is magnified by an integer factor in both directions. Horizontal magnification repeats each pixel on the stream. Vertical magnification fetches the same source row again for each repeated output line, so no line buffer is needed.

A frame is produced only on request. A pulse on `redraw_req` marks the image as stale. A later pulse on `start` then emits exactly one frame, and the stale mark is cleared when the final pixel of that frame is accepted. The output is a valid/ready stream. Backpressure stalls the whole pipe without dropping or repeating pixels. With the defaults (64-byte rows, 64 visible rows out of 80 stored, magnification 4), a frame is 512 × 256 pixels. Video timing is left to the consumer.

Top module: `nibble_scan_expander`

## Requirements
- R1: While reset is held, and after it is released, `pix_valid` and `fb_rd_en` are both 0.
- R2: A `start` pulse while no redraw is pending does nothing: no read is issued and no pixel is offered.
- R3: Within a frame, reads go through visible rows 0 to VIS_ROWS-1 in order. Each row is read MAG times in succession, with byte columns 0 to ROW_BYTES-1 ascending each time. The address is row × ROW_BYTES + column, so rows at or above VIS_ROWS are never read.
- R4: From each byte, the grey level in bits 7:4 is emitted first and the one in bits 3:0 second. Each is emitted MAG times in a row.
- R5: When `fmt_sel` is 1, `pix_data` is {G8, G8, G8}, where G8 = {g, g} for grey level g.
- R6: When `fmt_sel` is 0, `pix_data[23:16]` is 0 and `pix_data[15:0]` is {hi, lo}, where n = 2g + (g >> 3) (5 bits), lo = (n | n<<6 | ((n<<1) & 0x20)) mod 256 and hi = (n<<3 | n>>2) mod 256.
- R7: `fmt_sel` is sampled on the cycle a frame starts. Changes to it during a frame have no effect until the next frame.
- R8: While `pix_valid` is 1 and `pix_ready` is 0, `pix_data` and `pix_last` hold their values and `pix_valid` stays 1. No pixel is lost or duplicated.
- R9: A frame has exactly VIS_ROWS·MAG·ROW_BYTES·2·MAG pixels. `pix_last` is 1 on the final one only, and no pixel follows it.
- R10: Accepting the final pixel clears the pending redraw, unless `redraw_req` is 1 in that same cycle, in which case it stays pending and a later `start` runs another frame.
- R11: A `start` pulse during a frame is ignored. The frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redraw_req | input | 1 | Marks the framebuffer image as stale (sets the pending flag) |
| start | input | 1 | Begins a frame if a redraw is pending and no frame is running |
| fmt_sel | input | 1 | Output format: 0 = 16-bit 5-6-5 word, 1 = 24-bit grey triple |
| fb_rd_en | output | 1 | Framebuffer read strobe |
| fb_rd_addr | output | ADDR_W | Framebuffer byte address |
| fb_rd_data | input | 8 | Read data, valid the cycle after `fb_rd_en` |
| pix_valid | output | 1 | Pixel on `pix_data` is valid |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_data | output | 24 | Expanded colour value |
| pix_last | output | 1 | Final pixel of the frame |

## Verification
The bench uses a small geometry that is not a power of two (5-byte rows, 6 of 9 rows visible, magnification 3). An address computed as a shift, or a row counter that is off by one, would then show up as reads in the wrong order or reads of the hidden rows. Random backpressure drops `pix_ready` on the last repeat of a byte, which is where the held byte is replaced. A bad handoff there repeats or skips a nibble. The format input is flipped mid-frame and a second `start` is sent during the frame. Sampling the format late corrupts the colours, and honouring the extra start restarts the address sequence. `redraw_req` is raised exactly on the final handshake. A design that lets the clear win over the set would then ignore the next `start`. A design that never clears the pending flag would answer a `start` when no redraw is pending.

// File: rtl/nibble_scan_expander.sv
module nibble_scan_expander #(
  parameter int ROW_BYTES  = 64,
  parameter int VIS_ROWS   = 64,
  parameter int STORE_ROWS = 80,
  parameter int MAG        = 4,
  localparam int ADDR_W    = $clog2(STORE_ROWS * ROW_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redraw_req,
  input  logic              start,
  input  logic              fmt_sel,
  output logic              fb_rd_en,
  output logic [ADDR_W-1:0] fb_rd_addr,
  input  logic [7:0]        fb_rd_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [23:0]       pix_data,
  output logic              pix_last
);

  localparam int CW   = ROW_BYTES > 1 ? $clog2(ROW_BYTES) : 1;
  localparam int RW   = VIS_ROWS > 1 ? $clog2(VIS_ROWS) + 1 : 2;
  localparam int MW   = MAG > 1 ? $clog2(MAG) : 1;
  localparam int SUBS = 2 * MAG;
  localparam int SW   = $clog2(SUBS);
  localparam logic [CW-1:0] COL_LAST = CW'(ROW_BYTES - 1);
  localparam logic [MW-1:0] REP_LAST = MW'(MAG - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(VIS_ROWS - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);

  logic          pending, active, fmt_q;
  logic          fetch_done, rd_pend, rd_last;
  logic [CW-1:0] fcol;
  logic [MW-1:0] frep;
  logic [RW-1:0] frow;
  logic [7:0]    nxt, cur;
  logic          nxt_v, nxt_last, cur_v, cur_last;
  logic [SW-1:0] sub;

  logic frame_go, frame_end, cur_fin, load_cur, fetch_final;

  assign frame_go    = start && pending && !active;
  assign cur_fin     = cur_v && pix_ready && (sub == SUB_LAST);
  assign frame_end   = cur_fin && cur_last;
  assign load_cur    = nxt_v && (!cur_v || cur_fin);
  assign fetch_final = (fcol == COL_LAST) && (frep == REP_LAST) && (frow == ROW_LAST);

  assign fb_rd_en   = active && !fetch_done && !rd_pend && (!nxt_v || load_cur);
  assign fb_rd_addr = ADDR_W'(int'(frow) * ROW_BYTES + int'(fcol));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      active  <= 1'b0;
      fmt_q   <= 1'b0;
    end else begin
      if (frame_end)       pending <= redraw_req;
      else if (redraw_req) pending <= 1'b1;
      if (frame_go) begin
        active <= 1'b1;
        fmt_q  <= fmt_sel;
      end else if (frame_end) begin
        active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_done <= 1'b0;
      rd_pend    <= 1'b0;
      rd_last    <= 1'b0;
      fcol       <= '0;
      frep       <= '0;
      frow       <= '0;
    end else begin
      rd_pend <= fb_rd_en;
      if (frame_go) begin
        fetch_done <= 1'b0;
        fcol       <= '0;
        frep       <= '0;
        frow       <= '0;
      end else if (fb_rd_en) begin
        rd_last <= fetch_final;
        if (fetch_final) fetch_done <= 1'b1;
        if (fcol == COL_LAST) begin
          fcol <= '0;
          if (frep == REP_LAST) begin
            frep <= '0;
            frow <= frow + 1'b1;
          end else begin
            frep <= frep + 1'b1;
          end
        end else begin
          fcol <= fcol + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt      <= '0;
      nxt_v    <= 1'b0;
      nxt_last <= 1'b0;
    end else if (rd_pend) begin
      nxt      <= fb_rd_data;
      nxt_v    <= 1'b1;
      nxt_last <= rd_last;
    end else if (load_cur) begin
      nxt_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      cur_v    <= 1'b0;
      cur_last <= 1'b0;
      sub      <= '0;
    end else if (load_cur) begin
      cur      <= nxt;
      cur_v    <= 1'b1;
      cur_last <= nxt_last;
      sub      <= '0;
    end else if (cur_v && pix_ready) begin
      if (cur_fin) cur_v <= 1'b0;
      else         sub   <= sub + 1'b1;
    end
  end

  logic [3:0] nib;
  logic [4:0] n5;
  logic [7:0] lo565, hi565;

  assign nib   = (sub < SW'(MAG)) ? cur[7:4] : cur[3:0];
  assign n5    = {nib, nib[3]};
  assign lo565 = {3'b000, n5} | {n5[1:0], 6'b0} | ({2'b00, n5, 1'b0} & 8'h20);
  assign hi565 = {n5, 3'b000} | {5'b00000, n5[4:2]};

  assign pix_valid = cur_v;
  assign pix_last  = cur_v && cur_last && (sub == SUB_LAST);
  assign pix_data  = fmt_q ? {nib, nib, nib, nib, nib, nib} : {8'h00, hi565, lo565};

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data) && $stable(pix_last));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |-> int'(fb_rd_addr) < VIS_ROWS * ROW_BYTES);

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !pending && !active |=> !active);

  // R7
  fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(fmt_q));

  // R9
  end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && pix_last |=> !pix_valid && !fb_rd_en);

  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && pix_last && !redraw_req |=> !pending);

  // R10
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && pix_last && redraw_req |=> pending);

  // R3
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !nxt_v);

endmodule

// File: tb/nibble_scan_expander_test.sv
module nibble_scan_expander_test;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 5;
  localparam int VR = 6;
  localparam int SR = 9;
  localparam int MG = 3;
  localparam int AW = $clog2(SR * RB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redraw_req = 1'b0;
  logic start = 1'b0;
  logic fmt_sel = 1'b0;
  logic pix_ready = 1'b1;
  logic fb_rd_en;
  logic [AW-1:0] fb_rd_addr;
  logic [7:0] fb_rd_data = 8'h00;
  logic pix_valid, pix_last;
  logic [23:0] pix_data;

  logic [7:0] mem [SR*RB];
  int pq[$];
  bit lq[$];
  int aq[$];
  int checks = 0;
  int fails = 0;
  int seen_rd = 0;
  int seen_px = 0;
  int rmode = 0;
  bit arm = 1'b0;
  int unsigned rs = 32'h1234_5678;
  string ptag = "R4 R5";

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (fb_rd_en) fb_rd_data <= mem[fb_rd_addr];

  nibble_scan_expander #(.ROW_BYTES(RB), .VIS_ROWS(VR), .STORE_ROWS(SR), .MAG(MG)) uut (
    .clk(clk), .rst_n(rst_n), .redraw_req(redraw_req), .start(start), .fmt_sel(fmt_sel),
    .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data), .pix_last(pix_last));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic int colour(input int g, input bit f);
    int n, lo, hi;
    if (f) return (g * 17) * 65793;
    n  = 2 * g + (g >> 3);
    lo = (n | (n << 6) | ((n << 1) & 32)) & 255;
    hi = ((n << 3) | (n >> 2)) & 255;
    return hi * 256 + lo;
  endfunction

  task automatic build(input bit f);
    for (int r = 0; r < VR; r++)
      for (int k = 0; k < MG; k++)
        for (int c = 0; c < RB; c++) begin
          int b;
          aq.push_back(r * RB + c);
          b = int'(mem[r * RB + c]);
          for (int h = 0; h < 2; h++)
            for (int m = 0; m < MG; m++) begin
              pq.push_back(colour(h == 0 ? (b >> 4) : (b & 15), f));
              lq.push_back(r == VR-1 && k == MG-1 && c == RB-1 && h == 1 && m == MG-1);
            end
        end
  endtask

  task automatic fill(input int p);
    for (int i = 0; i < SR*RB; i++) begin
      if (i >= VR*RB) mem[i] = 8'hAA;
      else if (p == 0) mem[i] = 8'((i * 37 + 5) & 255);
      else if (p == 1) mem[i] = (i % 3 == 0) ? 8'hF0 : (i % 3 == 1) ? 8'h0F : 8'((i * 53) & 255);
      else mem[i] = 8'((i * 91 + 200) & 255);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    start = 1'b0;
    redraw_req = 1'b0;
    if (rmode == 0) pix_ready = 1'b1;
    else begin
      rs = rs * 1664525 + 1013904223;
      pix_ready = ((rs >> 16) % 4) != 0;
    end
    if (arm && pix_valid && pix_last && pix_ready) redraw_req = 1'b1;
  endtask

  task automatic wait_done(input string tag);
    while (pq.size() > 0 || aq.size() > 0) tick();
    repeat (4) tick();
    @(negedge clk);
    check(pq.size() == 0 && lq.size() == 0, {tag, " R9 pixel count"}, pq.size(), 0);
    check(!pix_valid && !fb_rd_en, {tag, " R9 idle after frame"}, pix_valid, 0);
  endtask

  initial begin : monitor
    bit pstall = 1'b0;
    logic [23:0] pdata = '0;
    logic plast = 1'b0;
    int e;
    bit el;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (fb_rd_en) begin
          seen_rd++;
          if (aq.size() == 0) check(1'b0, "R2 R10 unexpected read", fb_rd_addr, 0);
          else begin
            e = aq.pop_front();
            check(int'(fb_rd_addr) == e, "R3 read address", fb_rd_addr, e);
          end
        end
        if (pstall)
          check(pix_valid && pix_data == pdata && pix_last == plast, "R8 hold under stall",
                pix_data, pdata);
        if (pix_valid) seen_px++;
        if (pix_valid && pix_ready) begin
          if (pq.size() == 0) check(1'b0, "R9 extra pixel", pix_data, 0);
          else begin
            e  = pq.pop_front();
            el = lq.pop_front();
            check(pix_data == 24'(e), ptag, pix_data, e);
            check(pix_last == el, "R9 last flag", pix_last, el);
          end
        end
        pstall = pix_valid && !pix_ready;
        pdata  = pix_data;
        plast  = pix_last;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "R9 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin : main
    fill(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!pix_valid && !fb_rd_en, "R1 reset state", {pix_valid, fb_rd_en}, 0);
    tick();
    rst_n = 1'b1;
    tick();
    @(negedge clk);
    check(!pix_valid && !fb_rd_en, "R1 after reset", {pix_valid, fb_rd_en}, 0);

    seen_rd = 0; seen_px = 0;
    start = 1'b1;
    repeat (20) tick();
    check(seen_rd == 0 && seen_px == 0, "R2 start without pending", seen_rd + seen_px, 0);

    ptag = "R4 R5 true-colour pixel";
    fmt_sel = 1'b1; rmode = 0;
    redraw_req = 1'b1; tick();
    start = 1'b1; build(1'b1); tick();
    wait_done("F1");

    fill(1);
    ptag = "R4 R6 R7 565 pixel";
    fmt_sel = 1'b0; rmode = 1;
    redraw_req = 1'b1; tick();
    start = 1'b1; build(1'b0); tick();
    repeat (40) tick();
    fmt_sel = 1'b1;
    start = 1'b1;
    tick();
    wait_done("F2 R11");

    seen_rd = 0; seen_px = 0;
    start = 1'b1;
    repeat (20) tick();
    check(seen_rd == 0 && seen_px == 0, "R10 pending cleared", seen_rd + seen_px, 0);

    fill(2);
    ptag = "R6 565 pixel";
    fmt_sel = 1'b0;
    redraw_req = 1'b1; tick();
    start = 1'b1; build(1'b0); arm = 1'b1; tick();
    wait_done("F3");
    arm = 1'b0;

    ptag = "R5 true-colour pixel";
    fmt_sel = 1'b1; rmode = 0;
    seen_rd = 0;
    start = 1'b1; build(1'b1); tick();
    wait_done("F4 R10");
    check(seen_rd == VR*MG*RB, "R10 request on final handshake kept", seen_rd, VR*MG*RB);

    summary();
    $finish;
  end
endmodule